// File: doc/BRIEF.md
# Level-to-Pulse Interrupt Merger for Legacy PCI Interrupts

This block takes the four level-sensitive legacy interrupt wires of a PCI Express controller core and merges them onto one interrupt line that drives a host interrupt controller. That controller detects edges only, so the block sends a single-cycle pulse rather than a level. Each source has an enable bit and a sticky status bit. Software clears a status bit by writing a one to it.

Level behaviour is restored through an end-of-interrupt register. After the handler has finished, software writes a source index to that register. If any enabled source still has its status set at that moment, the block sends a new pulse. An interrupt that stays asserted is therefore never lost, even though the host sees only edges. A link-down event has its own enable and sticky status bit. It is visible through the registers only and never drives the pulse line.

The pulse sequencer has four states:
- `ST_IDLE`: no enabled source is pending.
- `ST_FIRE`: the pulse cycle.
- `ST_WAIT`: a source is still pending and the pulse has already been sent.
- `ST_REARM`: a forced low cycle after an end-of-interrupt write arrives during a pulse.

The transitions are:
- IDLE→FIRE when an enabled source becomes pending.
- FIRE→WAIT when the source is still pending.
- FIRE→IDLE when nothing is pending.
- FIRE→REARM on an accepted end-of-interrupt write.
- WAIT→IDLE when the pending condition drops.
- WAIT→FIRE on an accepted end-of-interrupt write.
- REARM→FIRE when a source is still pending.
- REARM→IDLE otherwise.

Top module: `intx_pulse_merge`

## Requirements
- R1: After reset, all enable bits and status bits are zero, `irq_pulse` is low and `bus_rdata` is zero.
- R2: The source-enable register at offset 0x100 holds enable bit n for source n in bits [3:0]. It reads back as written, and bits above 3 read as zero.
- R3: Status bit n (offset 0x500, bit n) becomes set in the cycle after `intx_lvl[n]` is sampled high while enable bit n is set. A disabled source never sets its status bit.
- R4: A write to offset 0x700 clears every status bit whose matching data bit is one, and leaves the other status bits unchanged. If the source level is still high, the bit sets again one cycle after the clear.
- R5: `irq_pulse` is high for exactly one cycle. It rises one cycle after the set of enabled, pending sources goes from empty to non-empty. No further pulse is sent while that set stays non-empty and no end-of-interrupt write is accepted.
- R6: A write to offset 0x10 with data 0 to 3 is accepted as end-of-interrupt. If the sequencer is waiting and a source is pending, `irq_pulse` is high in the next cycle. If the write coincides with a pulse cycle, one low cycle follows, and then another pulse if a source is still pending.
- R7: An end-of-interrupt write with data 4 or above has no effect. An accepted end-of-interrupt write while no enabled source is pending produces no pulse.
- R8: The link-down enable is bit 1 at offset 0x108. The link-down status is bit 1 at offset 0x508. It sets when `link_down` is sampled high while enabled, and is cleared by writing a one to bit 1 at offset 0x708. It never causes `irq_pulse`.
- R9: `bus_rdata` shows the register selected by `bus_addr` one cycle after the address is presented. Offsets with no readable register return zero. Writes to the status offsets 0x500 and 0x508 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| intx_lvl | input | 4 | Legacy interrupt levels, bit n is source n |
| link_down | input | 1 | Link-down event from the core |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| irq_pulse | output | 1 | Single-cycle interrupt pulse to the host |

## Verification
The sensitive collisions are an end-of-interrupt write landing in the very cycle the pulse is high, and a write-one-to-clear landing in the same cycle as a source level that is still high. The bench forces the first case by stepping until the sequencer is about to fire and then presenting the end-of-interrupt write in that cycle. It expects a low cycle followed by a second pulse. The bench forces the second case by holding a level high while clearing its bit. Random traffic then mixes all register writes with changing levels, and a cycle model built from the requirements judges every pulse and read value.

// File: rtl/intx_pkg.sv
package intx_pkg;

    // Register byte offsets (software decodes these)
    localparam int unsigned OFS_EOI      = 32'h010;
    localparam int unsigned OFS_SRC_EN   = 32'h100;
    localparam int unsigned OFS_LNK_EN   = 32'h108;
    localparam int unsigned OFS_SRC_ST   = 32'h500;
    localparam int unsigned OFS_LNK_ST   = 32'h508;
    localparam int unsigned OFS_SRC_CLR  = 32'h700;
    localparam int unsigned OFS_LNK_CLR  = 32'h708;

    // Bit carrying the link-down event in its enable/status/clear words
    localparam int unsigned LNK_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRE  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_REARM = 2'd3
    } pulse_st_e;

endpackage

// File: rtl/intx_regs.sv
module intx_regs
    import intx_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_SRC-1:0] st_src,
    input  logic               st_lnk,
    output logic [NUM_SRC-1:0] en_src,
    output logic               en_lnk,
    output logic [NUM_SRC-1:0] clr_src,
    output logic               clr_lnk,
    output logic               eoi_hit,
    output logic [DATA_W-1:0]  bus_rdata
);

    localparam logic [ADDR_W-1:0] A_EOI    = ADDR_W'(OFS_EOI);
    localparam logic [ADDR_W-1:0] A_SRC_EN = ADDR_W'(OFS_SRC_EN);
    localparam logic [ADDR_W-1:0] A_LNK_EN = ADDR_W'(OFS_LNK_EN);
    localparam logic [ADDR_W-1:0] A_SRC_ST = ADDR_W'(OFS_SRC_ST);
    localparam logic [ADDR_W-1:0] A_LNK_ST = ADDR_W'(OFS_LNK_ST);
    localparam logic [ADDR_W-1:0] A_SRC_CL = ADDR_W'(OFS_SRC_CLR);
    localparam logic [ADDR_W-1:0] A_LNK_CL = ADDR_W'(OFS_LNK_CLR);
    localparam logic [DATA_W-1:0] IDX_LIM  = DATA_W'(NUM_SRC);

    logic wr_src_en, wr_lnk_en, wr_src_cl, wr_lnk_cl, wr_eoi;
    logic [DATA_W-1:0] rd_next;

    // Write strobes
    always_comb begin
        wr_src_en = bus_we && (bus_addr == A_SRC_EN);
        wr_lnk_en = bus_we && (bus_addr == A_LNK_EN);
        wr_src_cl = bus_we && (bus_addr == A_SRC_CL);
        wr_lnk_cl = bus_we && (bus_addr == A_LNK_CL);
        wr_eoi    = bus_we && (bus_addr == A_EOI);
    end

    assign clr_src = wr_src_cl ? bus_wdata[NUM_SRC-1:0] : '0;
    assign clr_lnk = wr_lnk_cl && bus_wdata[LNK_BIT];
    assign eoi_hit = wr_eoi && (bus_wdata < IDX_LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_src <= '0;
            en_lnk <= 1'b0;
        end else begin
            if (wr_src_en) en_src <= bus_wdata[NUM_SRC-1:0];
            if (wr_lnk_en) en_lnk <= bus_wdata[LNK_BIT];
        end
    end

    // Read mux
    always_comb begin
        rd_next = '0;
        case (bus_addr)
            A_SRC_EN: rd_next[NUM_SRC-1:0] = en_src;
            A_SRC_ST: rd_next[NUM_SRC-1:0] = st_src;
            A_LNK_EN: rd_next[LNK_BIT]     = en_lnk;
            A_LNK_ST: rd_next[LNK_BIT]     = st_lnk;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

endmodule

// File: rtl/intx_src_bank.sv
module intx_src_bank #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lvl,
    input  logic [NUM_SRC-1:0] en_src,
    input  logic [NUM_SRC-1:0] clr_src,
    input  logic               lnk_evt,
    input  logic               en_lnk,
    input  logic               clr_lnk,
    output logic [NUM_SRC-1:0] st_src,
    output logic               st_lnk
);

    // One sticky flag per source; clear wins in its own cycle
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  st_src[g] <= 1'b0;
            else if (clr_src[g])         st_src[g] <= 1'b0;
            else if (lvl[g] && en_src[g]) st_src[g] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                st_lnk <= 1'b0;
        else if (clr_lnk)          st_lnk <= 1'b0;
        else if (lnk_evt && en_lnk) st_lnk <= 1'b1;
    end

endmodule

// File: rtl/intx_pulse_fsm.sv
module intx_pulse_fsm
    import intx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic eoi_hit,
    output logic irq_pulse
);

    pulse_st_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = pend ? ST_FIRE : ST_IDLE;
            ST_FIRE: begin
                if (eoi_hit)   state_nx = ST_REARM;
                else if (pend) state_nx = ST_WAIT;
                else           state_nx = ST_IDLE;
            end
            ST_WAIT: begin
                if (!pend)        state_nx = ST_IDLE;
                else if (eoi_hit) state_nx = ST_FIRE;
                else              state_nx = ST_WAIT;
            end
            ST_REARM: state_nx = pend ? ST_FIRE : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_pulse = (state == ST_FIRE);
    end

endmodule

// File: rtl/intx_pulse_merge.sv
module intx_pulse_merge #(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] intx_lvl,
    input  logic               link_down,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_pulse
);

    logic [NUM_SRC-1:0] en_src, st_src, clr_src;
    logic en_lnk, st_lnk, clr_lnk, eoi_hit, pend;

    assign pend = |(en_src & st_src);

    intx_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .st_src(st_src), .st_lnk(st_lnk),
        .en_src(en_src), .en_lnk(en_lnk),
        .clr_src(clr_src), .clr_lnk(clr_lnk),
        .eoi_hit(eoi_hit), .bus_rdata(bus_rdata)
    );

    intx_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .lvl(intx_lvl), .en_src(en_src), .clr_src(clr_src),
        .lnk_evt(link_down), .en_lnk(en_lnk), .clr_lnk(clr_lnk),
        .st_src(st_src), .st_lnk(st_lnk)
    );

    intx_pulse_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pend(pend), .eoi_hit(eoi_hit),
        .irq_pulse(irq_pulse)
    );

endmodule

// File: rtl/intx_pulse_chk.sv
module intx_pulse_chk
    import intx_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] intx_lvl,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_pulse,
    input logic [NUM_SRC-1:0] en_src,
    input logic [NUM_SRC-1:0] st_src,
    input logic               pend
);

    logic addr_known;
    always_comb begin
        addr_known = (bus_addr == ADDR_W'(OFS_SRC_EN)) || (bus_addr == ADDR_W'(OFS_SRC_ST)) ||
                     (bus_addr == ADDR_W'(OFS_LNK_EN)) || (bus_addr == ADDR_W'(OFS_LNK_ST));
    end

    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R5

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(pend)); // R5

    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_src & ~$past(st_src) & ~$past(en_src & intx_lvl)) == '0); // R3

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_SRC_CLR))
        |=> (st_src & $past(bus_wdata[NUM_SRC-1:0])) == '0); // R4

    AST_UNKNOWN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_known |=> bus_rdata == '0); // R9

endmodule

bind intx_pulse_merge intx_pulse_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .intx_lvl(intx_lvl),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_pulse(irq_pulse),
    .en_src(en_src), .st_src(st_src), .pend(pend)
);

// File: tb/tb_intx_pulse_merge.sv
`timescale 1ns/1ps
module tb_intx_pulse_merge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  intx_lvl = '0;
    logic        link_down = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pulse;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0] m_en = '0, m_st = '0;
    logic       m_len = 1'b0, m_lst = 1'b0;
    int         m_state = 0; // 0 idle 1 fire 2 wait 3 rearm

    always #4 clk = ~clk;

    intx_pulse_merge dut (
        .clk(clk), .rst_n(rst_n), .intx_lvl(intx_lvl), .link_down(link_down),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
    );

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] r = '0;
        case (a)
            12'h100: r[3:0] = m_en;
            12'h500: r[3:0] = m_st;
            12'h108: r[1]   = m_len;
            12'h508: r[1]   = m_lst;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic int exp_next_state(input int s, input logic pend, input logic eoi);
        case (s)
            0: return pend ? 1 : 0;
            1: return eoi ? 3 : (pend ? 2 : 0);
            2: return !pend ? 0 : (eoi ? 1 : 2);
            default: return pend ? 1 : 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    // One clock: drive, predict, sample after the edge
    task automatic cyc(input logic [3:0] lvl, input logic ld, input logic [11:0] a,
                       input logic w, input logic [31:0] d, input string tag);
        logic pend, eoi, lclr;
        logic [3:0] clr, nst, nen;
        logic nlst, nlen;
        logic [31:0] rd;
        int ns;
        intx_lvl = lvl; link_down = ld; bus_addr = a; bus_we = w; bus_wdata = d;
        pend = |(m_en & m_st);
        eoi  = w && (a == 12'h010) && (d < 32'd4);
        ns   = exp_next_state(m_state, pend, eoi);
        rd   = exp_read(a);
        clr  = (w && a == 12'h700) ? d[3:0] : 4'h0;
        nst  = (m_st | (lvl & m_en)) & ~clr;
        lclr = w && (a == 12'h708) && d[1];
        nlst = lclr ? 1'b0 : (m_lst | (ld & m_len));
        nen  = (w && a == 12'h100) ? d[3:0] : m_en;
        nlen = (w && a == 12'h108) ? d[1] : m_len;
        @(posedge clk);
        #2;
        chk(tag, "irq_pulse", {31'b0, irq_pulse}, {31'b0, ns == 1});
        chk(tag, "bus_rdata", bus_rdata, rd);
        m_state = ns; m_st = nst; m_lst = nlst; m_en = nen; m_len = nlen;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [11:0] pool [10];
        void'($urandom(32'd20240611));
        pool = '{12'h010, 12'h100, 12'h108, 12'h500, 12'h508,
                 12'h700, 12'h708, 12'h004, 12'h010, 12'h7FC};

        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1", "irq_pulse at reset", {31'b0, irq_pulse}, 32'h0);
        chk("R1", "bus_rdata at reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(4'h0, 0, 12'h100, 0, 0, "R1");
        cyc(4'h0, 0, 12'h500, 0, 0, "R1");

        // R2 enable write/readback, upper bits dropped
        cyc(4'h0, 0, 12'h100, 1, 32'hFFFF_FFF5, "R2");
        cyc(4'h0, 0, 12'h100, 0, 0, "R2");

        // R3 disabled sources stay clear
        repeat (3) cyc(4'b1010, 0, 12'h500, 0, 0, "R3");
        // R3 enabled source sets, R5 single pulse
        cyc(4'b0001, 0, 12'h500, 0, 0, "R3");
        repeat (6) cyc(4'b0001, 0, 12'h500, 0, 0, "R5");

        // R6 accepted end-of-interrupt while pending
        cyc(4'b0001, 0, 12'h010, 1, 32'd2, "R6");
        repeat (3) cyc(4'b0001, 0, 12'h500, 0, 0, "R6");

        // R7 out-of-range index ignored
        cyc(4'b0001, 0, 12'h010, 1, 32'd4, "R7");
        cyc(4'b0001, 0, 12'h010, 1, 32'hFFFF_FFFF, "R7");
        repeat (2) cyc(4'b0001, 0, 12'h500, 0, 0, "R7");

        // R4 clear with level still high re-sets
        cyc(4'b0001, 0, 12'h700, 1, 32'h1, "R4");
        cyc(4'b0001, 0, 12'h500, 0, 0, "R4");
        cyc(4'b0001, 0, 12'h500, 0, 0, "R4");
        // R4 clear with level low stays clear, unselected bits untouched
        cyc(4'b0100, 0, 12'h700, 1, 32'h1, "R4");
        repeat (3) cyc(4'b0000, 0, 12'h500, 0, 0, "R4");
        cyc(4'b0000, 0, 12'h700, 1, 32'hF, "R4");
        repeat (2) cyc(4'b0000, 0, 12'h500, 0, 0, "R4");

        // R7 accepted index with nothing pending
        cyc(4'b0000, 0, 12'h010, 1, 32'd0, "R7");
        repeat (2) cyc(4'b0000, 0, 12'h500, 0, 0, "R7");

        // R6 collision: end-of-interrupt during the pulse cycle
        cyc(4'b0100, 0, 12'h500, 0, 0, "R6");
        while (m_state != 1) cyc(4'b0100, 0, 12'h500, 0, 0, "R6");
        cyc(4'b0100, 0, 12'h010, 1, 32'd3, "R6");
        repeat (4) cyc(4'b0100, 0, 12'h500, 0, 0, "R6");
        cyc(4'b0000, 0, 12'h700, 1, 32'hF, "R6");
        repeat (2) cyc(4'b0000, 0, 12'h500, 0, 0, "R6");

        // R8 link-down path
        cyc(4'b0000, 1, 12'h508, 0, 0, "R8");
        cyc(4'b0000, 0, 12'h108, 1, 32'h2, "R8");
        cyc(4'b0000, 1, 12'h108, 0, 0, "R8");
        repeat (3) cyc(4'b0000, 0, 12'h508, 0, 0, "R8");
        cyc(4'b0000, 0, 12'h708, 1, 32'h2, "R8");
        cyc(4'b0000, 0, 12'h508, 0, 0, "R8");

        // R9 unknown offsets and read-only writes
        cyc(4'b0000, 0, 12'h004, 0, 0, "R9");
        cyc(4'b0000, 0, 12'h500, 1, 32'hF, "R9");
        cyc(4'b0000, 0, 12'h508, 1, 32'h2, "R9");
        cyc(4'b0000, 0, 12'h500, 0, 0, "R9");
        cyc(4'b0000, 0, 12'h700, 0, 0, "R9");
        cyc(4'b0000, 0, 12'h010, 0, 0, "R9");

        // Random mix: R5 pulses and R9 reads judged by the model
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic w;
            a = pool[$urandom_range(0, 9)];
            w = ($urandom_range(0, 3) == 0);
            d = (a == 12'h010) ? 32'($urandom_range(0, 7)) : $urandom;
            cyc(4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)),
                ($urandom_range(0, 7) == 0), a, w, d, "R5");
        end

        finish_run();
    end

endmodule